// File: doc/BRIEF.md
# Dual-Bank SPI Packet Buffer Writer

This block is the SPI slave entry point through which a host loads transmit payload into one of two packet buffers. Each buffer holds 64 words of 16 bits. The host frames a transaction by pulling chip-enable low and sends a header byte first. If the header is a write to the packet-buffer address, every following pair of data bytes becomes one 16-bit word. The words are stored at consecutive addresses, starting from word 0, in the bank that the bank-select input names.

The same bank-select input also chooses the bank that the transmit sequencer reads through the registered read port. Two faults are recorded in sticky status bits. The first is a burst that runs past the end of the buffer. The second is a word that completes while the transmit sequencer is busy with the buffer. Each status bit has its own mask bit, and an interrupt is raised when a set status bit is also unmasked. A read strobe on the status clears both bits.

A full payload is at most 125 data bytes. The host pads an odd payload with one dummy byte so that every word it sends is complete.

Top module: `spi_pktbuf_writer`

## Requirements
- R1: The first byte after chip-enable falls is a header. Bit 7 is the direction (0 = write) and bits 5:0 are the register address. Bit 6 is ignored. Data bytes are stored only when bit 7 is 0 and the address equals BUF_REG (default 2). For any other header, the data bytes of that transaction change no buffer word.
- R2: The first data byte of a pair is stored in bits 15:8 of the word and the second in bits 7:0. Words are stored at addresses 0, 1, 2, … from the start of each transaction.
- R3: A word is stored only when its second byte completes. A single trailing byte that is still waiting when chip-enable rises is discarded.
- R4: When bank_sel is 0 at the falling edge of chip-enable, the transaction writes bank 0. When it is 1, the transaction writes bank 1. tx_rd_data returns the word at tx_rd_addr from the bank named by bank_sel, one clock cycle after both are applied.
- R5: When a data byte arrives after DEPTH words have been counted in a transaction, status bit 0 (address error) is set. No further words of that transaction are stored, and the address does not wrap.
- R6: When a word completes while tx_busy is high, status bit 1 (arbitration error) is set and that word is not stored. The word address still advances.
- R7: The status bits stay set until status_rd is pulsed, which clears them. An error that occurs in the same cycle as the clear still sets its bit.
- R8: irq is a registered copy of the OR of (status AND irq_mask), so it follows the status and mask one cycle later.
- R9: After a synchronous reset, status and irq are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | SPI serial clock (mode 0), sampled by clk |
| spi_mosi | input | 1 | SPI data in, MSB first |
| spi_cs_n | input | 1 | Chip-enable, active low, frames a transaction |
| bank_sel | input | 1 | Bank choice for SPI writes and for the read port |
| tx_busy | input | 1 | Transmit sequencer is using the buffer |
| tx_rd_addr | input | ADDR_W | Read-port word address |
| tx_rd_data | output | 16 | Registered read-port word |
| irq_mask | input | 2 | Mask per status bit (bit 0 address error, bit 1 arbitration error) |
| status_rd | input | 1 | Status read strobe; clears the status bits |
| status | output | 2 | Sticky error status |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with ADDR_W = 3, which gives 8 words per bank. At that size, a transaction only needs 17 data bytes to run past the end of a buffer. This lets the bench sweep every byte count from 0 to 19 in both banks, covering even counts, odd counts, an exactly full buffer and an overflow. After each transaction it reads back every word of both banks. Dedicated transactions cover rejected headers, a write made while the sequencer is busy, and the four mask combinations.

// File: rtl/spi_pkt_pkg.sv
package spi_pkt_pkg;
  localparam int HDR_ADDR_W = 6;
  localparam int WORD_W     = 16;
  localparam int ST_W       = 2;
  localparam int ST_ADDR    = 0;
  localparam int ST_ARB     = 1;
endpackage

// File: rtl/spi_pkt_rx.sv
module spi_pkt_rx (
  input  logic       clk,
  input  logic       rst,
  input  logic       sclk,
  input  logic       mosi,
  input  logic       cs_n,
  output logic       cs_fall,
  output logic       cs_rise,
  output logic       byte_vld,
  output logic [7:0] byte_q
);
  logic [2:0] sclk_sr;
  logic [1:0] mosi_sr;
  logic [2:0] cs_sr;
  logic [2:0] bit_cnt;
  logic [6:0] shreg;
  logic       sclk_rise;
  logic       cs_low;

  assign sclk_rise = sclk_sr[1] & ~sclk_sr[2];
  assign cs_low    = ~cs_sr[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_sr  <= '0;
      mosi_sr  <= '0;
      cs_sr    <= '1;
      bit_cnt  <= '0;
      shreg    <= '0;
      byte_vld <= 1'b0;
      byte_q   <= '0;
      cs_fall  <= 1'b0;
      cs_rise  <= 1'b0;
    end else begin
      sclk_sr  <= {sclk_sr[1:0], sclk};
      mosi_sr  <= {mosi_sr[0], mosi};
      cs_sr    <= {cs_sr[1:0], cs_n};
      cs_fall  <= cs_sr[2] & ~cs_sr[1];
      cs_rise  <= ~cs_sr[2] & cs_sr[1];
      byte_vld <= 1'b0;
      if (!cs_low) begin
        bit_cnt <= '0;
      end else if (sclk_rise) begin
        shreg   <= {shreg[5:0], mosi_sr[1]};
        bit_cnt <= bit_cnt + 3'd1;
        if (bit_cnt == 3'd7) begin
          byte_vld <= 1'b1;
          byte_q   <= {shreg, mosi_sr[1]};
        end
      end
    end
  end
endmodule

// File: rtl/spi_pkt_framer.sv
module spi_pkt_framer
  import spi_pkt_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int BUF_REG = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_fall,
  input  logic              cs_rise,
  input  logic              byte_vld,
  input  logic [7:0]        byte_in,
  input  logic              tx_busy,
  input  logic              bank_sel,
  output logic              wr_en,
  output logic              wr_bank,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic              addr_err,
  output logic              arb_err
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CNT_W = ADDR_W + 1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
  localparam logic [HDR_ADDR_W-1:0] REG_ID = HDR_ADDR_W'(BUF_REG);

  logic             hdr_wait;
  logic             active;
  logic             have_hi;
  logic [7:0]       hi_q;
  logic [CNT_W-1:0] cnt;
  logic             bank_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hdr_wait <= 1'b0;
      active   <= 1'b0;
      have_hi  <= 1'b0;
      hi_q     <= '0;
      cnt      <= '0;
      bank_q   <= 1'b0;
      wr_en    <= 1'b0;
      wr_bank  <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      addr_err <= 1'b0;
      arb_err  <= 1'b0;
    end else begin
      wr_en    <= 1'b0;
      addr_err <= 1'b0;
      arb_err  <= 1'b0;
      if (cs_fall) begin
        hdr_wait <= 1'b1;
        active   <= 1'b0;
        have_hi  <= 1'b0;
        cnt      <= '0;
        bank_q   <= bank_sel;
      end else if (cs_rise) begin
        hdr_wait <= 1'b0;
        active   <= 1'b0;
        have_hi  <= 1'b0;
      end else if (byte_vld) begin
        if (hdr_wait) begin
          hdr_wait <= 1'b0;
          active   <= !byte_in[7] && (byte_in[HDR_ADDR_W-1:0] == REG_ID);
        end else if (active) begin
          if (cnt == CNT_FULL) begin
            addr_err <= 1'b1;
          end else if (!have_hi) begin
            hi_q    <= byte_in;
            have_hi <= 1'b1;
          end else begin
            have_hi <= 1'b0;
            cnt     <= cnt + 1'b1;
            if (tx_busy) begin
              arb_err <= 1'b1;
            end else begin
              wr_en   <= 1'b1;
              wr_bank <= bank_q;
              wr_addr <= cnt[ADDR_W-1:0];
              wr_data <= {hi_q, byte_in};
            end
          end
        end
      end
    end
  end

  // R5
  wr_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> ($past(cnt) < CNT_FULL));

  // R6
  busy_block_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !$past(tx_busy));

  // R2
  addr_restart_chk: assert property (@(posedge clk) disable iff (rst)
    cs_fall |=> (cnt == '0) && !have_hi);
endmodule

// File: rtl/spi_pkt_banks.sv
module spi_pkt_banks
  import spi_pkt_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              wr_bank,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_sel,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic sel_q;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [WORD_W-1:0] mem [DEPTH];
    logic [WORD_W-1:0] rd_q;
    always_ff @(posedge clk) begin
      if (wr_en && (wr_bank == b[0])) mem[wr_addr] <= wr_data;
      rd_q <= mem[rd_addr];
    end
  end

  always_ff @(posedge clk) sel_q <= rd_sel;

  assign rd_data = sel_q ? g_bank[1].rd_q : g_bank[0].rd_q;
endmodule

// File: rtl/spi_pktbuf_writer.sv
module spi_pktbuf_writer
  import spi_pkt_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int BUF_REG = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              spi_sclk,
  input  logic              spi_mosi,
  input  logic              spi_cs_n,
  input  logic              bank_sel,
  input  logic              tx_busy,
  input  logic [ADDR_W-1:0] tx_rd_addr,
  output logic [15:0]       tx_rd_data,
  input  logic [1:0]        irq_mask,
  input  logic              status_rd,
  output logic [1:0]        status,
  output logic              irq
);
  logic              cs_fall, cs_rise, byte_vld;
  logic [7:0]        byte_q;
  logic              wr_en, wr_bank;
  logic [ADDR_W-1:0] wr_addr;
  logic [WORD_W-1:0] wr_data;
  logic              addr_err, arb_err;
  logic [ST_W-1:0]   events;

  spi_pkt_rx u_rx (
    .clk(clk), .rst(rst), .sclk(spi_sclk), .mosi(spi_mosi), .cs_n(spi_cs_n),
    .cs_fall(cs_fall), .cs_rise(cs_rise), .byte_vld(byte_vld), .byte_q(byte_q)
  );

  spi_pkt_framer #(.ADDR_W(ADDR_W), .BUF_REG(BUF_REG)) u_framer (
    .clk(clk), .rst(rst), .cs_fall(cs_fall), .cs_rise(cs_rise),
    .byte_vld(byte_vld), .byte_in(byte_q), .tx_busy(tx_busy), .bank_sel(bank_sel),
    .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr), .wr_data(wr_data),
    .addr_err(addr_err), .arb_err(arb_err)
  );

  spi_pkt_banks #(.ADDR_W(ADDR_W)) u_banks (
    .clk(clk), .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_sel(bank_sel), .rd_addr(tx_rd_addr), .rd_data(tx_rd_data)
  );

  always_comb begin
    events          = '0;
    events[ST_ADDR] = addr_err;
    events[ST_ARB]  = arb_err;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status <= '0;
      irq    <= 1'b0;
    end else begin
      status <= (status_rd ? '0 : status) | events;
      irq    <= |(status & irq_mask);
    end
  end

  // R7
  status_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (status_rd && (events == '0)) |=> (status == '0));

  // R7
  status_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !status_rd |=> ((status & $past(status)) == $past(status)));

  // R8
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    ((status & irq_mask) == '0) |=> !irq);

  // R8
  irq_raise_chk: assert property (@(posedge clk) disable iff (rst)
    ((status & irq_mask) != '0) |=> irq);
endmodule

// File: tb/spi_pktbuf_writer_tb_top.sv
module spi_pktbuf_writer_tb_top;
  localparam int AW   = 3;
  localparam int D    = 1 << AW;
  localparam int HALF = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          sclk = 1'b0, mosi = 1'b0, cs_n = 1'b1;
  logic          bank_sel = 1'b0, tx_busy = 1'b0, status_rd = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [15:0]   rd_data;
  logic [1:0]    irq_mask = 2'b11;
  logic [1:0]    status;
  logic          irq;

  int checks = 0;
  int errs   = 0;
  int trial  = 0;
  logic [15:0] exp_mem [2][D];
  bit          exp_ok  [2][D];

  always #5 clk = ~clk;

  spi_pktbuf_writer #(.ADDR_W(AW), .BUF_REG(2)) dut_i (
    .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_mosi(mosi), .spi_cs_n(cs_n),
    .bank_sel(bank_sel), .tx_busy(tx_busy), .tx_rd_addr(rd_addr), .tx_rd_data(rd_data),
    .irq_mask(irq_mask), .status_rd(status_rd), .status(status), .irq(irq)
  );

  function automatic logic [7:0] pat(int t, int k);
    return 8'(t * 37 + k * 11 + 5);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      mosi = b[i];
      repeat (HALF) @(negedge clk);
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic xfer(input logic [7:0] hdr, input int n, input logic busy,
                      input logic bank, output logic [1:0] exp_st);
    bit ok;
    trial++;
    ok = !hdr[7] && (hdr[5:0] == 6'd2);
    bank_sel = bank;
    tx_busy  = busy;
    cs_n     = 1'b0;
    repeat (6) @(negedge clk);
    send_byte(hdr);
    for (int k = 0; k < n; k++) send_byte(pat(trial, k));
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (10) @(negedge clk);
    tx_busy = 1'b0;
    exp_st = 2'b00;
    if (ok) begin
      for (int i = 0; i < n / 2 && i < D; i++) begin
        if (!busy) begin
          exp_mem[bank][i] = {pat(trial, 2 * i), pat(trial, 2 * i + 1)};
          exp_ok[bank][i]  = 1'b1;
        end
      end
      exp_st[0] = (n > 2 * D);
      exp_st[1] = busy && (n >= 2);
    end
  endtask

  task automatic check_status(input string tag, input logic [1:0] exp_st);
    chk(tag, 32'(status), 32'(exp_st));
    chk({tag, " R8 irq"}, 32'(irq), 32'(|(exp_st & irq_mask)));
  endtask

  task automatic clear_status();
    status_rd = 1'b1;
    @(negedge clk);
    status_rd = 1'b0;
    repeat (2) @(negedge clk);
    chk("R7 status cleared", 32'(status), 32'd0);
    chk("R8 irq after clear", 32'(irq), 32'd0);
  endtask

  task automatic readback(input string tag);
    for (int b = 0; b < 2; b++) begin
      bank_sel = b[0];
      for (int a = 0; a < D; a++) begin
        rd_addr = a[AW-1:0];
        repeat (2) @(negedge clk);
        if (exp_ok[b][a]) chk(tag, 32'(rd_data), 32'(exp_mem[b][a]));
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    logic [1:0] st;
    for (int b = 0; b < 2; b++)
      for (int a = 0; a < D; a++) exp_ok[b][a] = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 status after reset", 32'(status), 32'd0);
    chk("R9 irq after reset", 32'(irq), 32'd0);

    // Sweep byte counts in both banks: R2 pairing, R3 odd tail, R4 banks, R5 overflow
    for (int b = 0; b < 2; b++) begin
      for (int n = 0; n <= 2 * D + 3; n++) begin
        xfer(8'h02, n, 1'b0, b[0], st);
        check_status("R5 status after sweep write", st);
        clear_status();
        readback("R2 R3 R4 word readback");
      end
    end

    // R1: wrong address, read direction, and ignored bit 6
    xfer(8'h03, 6, 1'b0, 1'b0, st);
    check_status("R1 wrong address status", st);
    readback("R1 wrong address leaves words");
    xfer(8'h82, 6, 1'b0, 1'b1, st);
    check_status("R1 read header status", st);
    readback("R1 read header leaves words");
    xfer(8'h42, 4, 1'b0, 1'b1, st);
    readback("R1 bit6 ignored write");

    // R6: busy sequencer blocks words and flags arbitration
    xfer(8'h02, 6, 1'b1, 1'b0, st);
    check_status("R6 arbitration status", st);
    chk("R6 expected arb bit", 32'(st), 32'd2);
    readback("R6 blocked words unchanged");
    clear_status();

    // R8 masks and R7 stickiness
    irq_mask = 2'b00;
    xfer(8'h02, 2 * D + 2, 1'b0, 1'b0, st);
    check_status("R8 masked overflow", st);
    irq_mask = 2'b01;
    repeat (2) @(negedge clk);
    chk("R8 irq unmasked addr", 32'(irq), 32'd1);
    irq_mask = 2'b10;
    repeat (2) @(negedge clk);
    chk("R8 irq other mask", 32'(irq), 32'd0);
    repeat (20) @(negedge clk);
    chk("R7 status sticky", 32'(status), 32'd1);
    clear_status();
    xfer(8'h02, 2, 1'b1, 1'b1, st);
    check_status("R8 arb unmasked", st);
    chk("R8 irq arb", 32'(irq), 32'd1);
    clear_status();
    readback("R4 final readback");

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule